// File: doc/BRIEF.md
# Transmit Descriptor Status Register Bank

This block keeps the per-descriptor control and status words for the transmit path of a 10/100 Ethernet MAC. There are `NDESC` descriptors, four by default, and each one is a 32-bit word. The host queues a packet by writing a whole word. That word carries the byte count, the early-start threshold code and a cleared ownership flag. The same write wipes the result flags left by the previous packet that used the descriptor.

The transmit engine reports back through a status-update port. That port carries a descriptor index, a strobe and two qualifiers. One qualifier marks DMA completion, which sets ownership. The other loads the final result flags: carrier loss, abort, late collision, missing heartbeat, collision count, success and underrun.

The block also decides when the engine may begin sending. Descriptors are served strictly in ring order. The head descriptor starts once the FIFO fill reaches its threshold, or once a complete packet sits in the FIFO. A packet longer than the long-packet limit holds the ring until the engine hands that descriptor back.

Top module: `txdesc_bank`

## Requirements
- R1: After reset every descriptor word reads 0x0000_2000: ownership (bit 13) is one and every other bit is zero.
- R2: A full write stores the byte count in bits 12:0, the ownership flag in bit 13 and the threshold code in bits 21:16. Bits 23:22 always read zero.
- R3: Host writes leave the host-read-only bits untouched. These are bits 31:24, 15 and 14.
- R4: A full host write to a descriptor clears its result flags: bits 31:28, 27:24, 15 and 14.
- R5: A write whose four byte enables are not all one changes nothing.
- R6: A status load on the update port stores its flags in fixed positions: carrier lost in bit 31, abort in 30, late collision in 29, heartbeat fail in 28, collision count in 27:24, transmit OK in 15 and underrun in 14.
- R7: While `link_100m` is high, a status load stores the heartbeat-fail bit as zero.
- R8: A DMA-completion update sets the ownership bit of the indexed descriptor.
- R9: When a status load and a host write hit the same descriptor in one cycle, the status bits take the loaded values. The host still sets the count, the threshold and the ownership bit.
- R10: Threshold code 0 means 8 bytes, and codes 1 to 63 mean the code times 32 bytes. The head descriptor starts when `fifo_level` is at or above that level, or when `fifo_pkt_done` is high.
- R11: `tx_start` is a one-cycle pulse, given once for each write that queues a descriptor. A descriptor whose ownership bit is one never starts.
- R12: After starting a descriptor whose count is above 1792, no later descriptor starts until that descriptor's ownership bit has been set. A count of exactly 1792 does not hold the ring.
- R13: `host_rd_data` shows the word selected by `host_rd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_addr | input | IDX_W | Descriptor written |
| host_wr_data | input | 32 | Write data |
| host_be | input | 4 | Byte enables; all four must be set |
| host_rd_addr | input | IDX_W | Descriptor read |
| host_rd_data | output | 32 | Registered read data |
| link_100m | input | 1 | Link runs at 100 Mbps |
| hw_upd | input | 1 | Status-update strobe |
| hw_idx | input | IDX_W | Descriptor being updated |
| hw_own_set | input | 1 | DMA finished: set ownership |
| hw_stat_load | input | 1 | Load the result flags below |
| hw_crs | input | 1 | Carrier lost |
| hw_tabt | input | 1 | Transmission aborted |
| hw_owc | input | 1 | Out-of-window collision |
| hw_hbf | input | 1 | Heartbeat missing |
| hw_ncc | input | 4 | Collision count |
| hw_tok | input | 1 | Transmit OK |
| hw_tun | input | 1 | FIFO underrun |
| fifo_level | input | LVL_W | Bytes held in the FIFO for the head packet |
| fifo_pkt_done | input | 1 | FIFO holds the complete head packet |
| tx_start | output | 1 | Start pulse |
| tx_start_idx | output | IDX_W | Descriptor that started |

## Verification
The bench uses the defaults: four descriptors, a 12-bit FIFO level and a long-packet limit of 1792. With a 12-bit level, both sides of every threshold edge can be driven. That covers code 0 at 7 and 8 bytes, the 32-byte steps, and the top code at 2015 and 2016 bytes. With four descriptors, the vector walk takes the ring head around the wrap more than once. The limit of 1792 can be approached from both sides with counts of 1792 and 1800.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int WORD_W = 32;
  localparam int SIZE_W = 13;
  localparam int THR_W  = 6;
  localparam int NCC_W  = 4;

  typedef struct packed {
    logic             crs;
    logic             tabt;
    logic             owc;
    logic             hbf;
    logic [NCC_W-1:0] ncc;
    logic             tok;
    logic             tun;
  } txd_stat_t;

  function automatic logic [WORD_W-1:0] txd_pack(input txd_stat_t st,
                                                 input logic [THR_W-1:0] thr,
                                                 input logic own,
                                                 input logic [SIZE_W-1:0] size);
    return {st.crs, st.tabt, st.owc, st.hbf, st.ncc, 2'b00, thr,
            st.tok, st.tun, own, size};
  endfunction
endpackage

// File: rtl/txd_slot.sv
module txd_slot
  import txd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_acc,
  input  logic [THR_W-1:0]      wr_thr,
  input  logic                  wr_own,
  input  logic [SIZE_W-1:0]     wr_size,
  input  logic                  upd_own,
  input  logic                  upd_stat,
  input  txd_stat_t             stat_in,
  input  logic                  start_clr,
  output logic [WORD_W-1:0]     word,
  output logic                  own,
  output logic                  armed,
  output logic [SIZE_W-1:0]     size,
  output logic [THR_W-1:0]      thr,
  output logic                  stat_nz,
  output logic                  hbf
);
  txd_stat_t stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      thr    <= '0;
      own    <= 1'b1;
      size   <= '0;
      armed  <= 1'b0;
    end else begin
      if (wr_acc) begin
        thr    <= wr_thr;
        size   <= wr_size;
        own    <= wr_own;
        stat_q <= '0;
      end
      // engine report overrides the host clear
      if (upd_stat) stat_q <= stat_in;
      if (upd_own)  own    <= 1'b1;
      if (wr_acc)         armed <= ~wr_own;
      else if (start_clr) armed <= 1'b0;
    end
  end

  always_comb begin
    word    = txd_pack(stat_q, thr, own, size);
    stat_nz = |stat_q;
    hbf     = stat_q.hbf;
  end
endmodule

// File: rtl/txd_thresh.sv
module txd_thresh #(
  parameter int THR_W      = 6,
  parameter int LVL_W      = 12,
  parameter int UNIT_SHIFT = 5,
  parameter int ZERO_BYTES = 8
) (
  input  logic [THR_W-1:0] code,
  output logic [LVL_W-1:0] bytes
);
  always_comb begin
    if (code == '0) bytes = LVL_W'(ZERO_BYTES);
    else            bytes = LVL_W'(code) << UNIT_SHIFT;
  end
endmodule

// File: rtl/txd_sched.sv
module txd_sched #(
  parameter int NDESC    = 4,
  parameter int LVL_W    = 12,
  parameter int SIZE_W   = 13,
  parameter int LONG_LIM = 1792,
  localparam int IDX_W   = (NDESC > 1) ? $clog2(NDESC) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NDESC-1:0]                  armed,
  input  logic [NDESC-1:0]                  own,
  input  logic [NDESC-1:0][SIZE_W-1:0]      size,
  input  logic [NDESC-1:0][LVL_W-1:0]       thr_bytes,
  input  logic [LVL_W-1:0]                  fifo_level,
  input  logic                              fifo_pkt_done,
  output logic [NDESC-1:0]                  start_clr,
  output logic                              tx_start,
  output logic [IDX_W-1:0]                  tx_start_idx
);
  logic [IDX_W-1:0] head, head_nxt;
  logic             wait_own;
  logic             ready, is_long;

  always_comb begin
    head_nxt  = (head == IDX_W'(NDESC-1)) ? '0 : head + 1'b1;
    ready     = !wait_own && armed[head] && !own[head] &&
                ((fifo_level >= thr_bytes[head]) || fifo_pkt_done);
    is_long   = size[head] > SIZE_W'(LONG_LIM);
    start_clr = '0;
    if (ready) start_clr[head] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head         <= '0;
      wait_own     <= 1'b0;
      tx_start     <= 1'b0;
      tx_start_idx <= '0;
    end else begin
      tx_start <= ready;
      if (ready) begin
        tx_start_idx <= head;
        if (is_long) wait_own <= 1'b1;
        else         head     <= head_nxt;
      end else if (wait_own && own[head]) begin
        wait_own <= 1'b0;
        head     <= head_nxt;
      end
    end
  end
endmodule

// File: rtl/txdesc_bank.sv
module txdesc_bank
  import txd_pkg::*;
#(
  parameter int NDESC    = 4,
  parameter int LVL_W    = 12,
  parameter int LONG_LIM = 1792,
  localparam int IDX_W   = (NDESC > 1) ? $clog2(NDESC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr_en,
  input  logic [IDX_W-1:0]   host_wr_addr,
  input  logic [31:0]        host_wr_data,
  input  logic [3:0]         host_be,
  input  logic [IDX_W-1:0]   host_rd_addr,
  output logic [31:0]        host_rd_data,
  input  logic               link_100m,
  input  logic               hw_upd,
  input  logic [IDX_W-1:0]   hw_idx,
  input  logic               hw_own_set,
  input  logic               hw_stat_load,
  input  logic               hw_crs,
  input  logic               hw_tabt,
  input  logic               hw_owc,
  input  logic               hw_hbf,
  input  logic [3:0]         hw_ncc,
  input  logic               hw_tok,
  input  logic               hw_tun,
  input  logic [LVL_W-1:0]   fifo_level,
  input  logic               fifo_pkt_done,
  output logic               tx_start,
  output logic [IDX_W-1:0]   tx_start_idx
);
  logic [NDESC-1:0][WORD_W-1:0] words;
  logic [NDESC-1:0]             own_vec, armed_vec, stat_nz, hbf_vec, start_clr;
  logic [NDESC-1:0][SIZE_W-1:0] size_vec;
  logic [NDESC-1:0][THR_W-1:0]  thr_vec;
  logic [NDESC-1:0][LVL_W-1:0]  thr_bytes;
  logic                         wr_full;
  txd_stat_t                    stat_in;
  logic                         unused_wr_bits;

  assign unused_wr_bits = ^{host_wr_data[31:22], host_wr_data[15:14]};
  assign wr_full        = host_wr_en && (host_be == 4'hF);

  always_comb begin
    stat_in.crs  = hw_crs;
    stat_in.tabt = hw_tabt;
    stat_in.owc  = hw_owc;
    stat_in.hbf  = hw_hbf & ~link_100m;
    stat_in.ncc  = hw_ncc;
    stat_in.tok  = hw_tok;
    stat_in.tun  = hw_tun;
  end

  for (genvar i = 0; i < NDESC; i++) begin : g_desc
    logic sel_wr, sel_hw;
    assign sel_wr = wr_full && (host_wr_addr == IDX_W'(i));
    assign sel_hw = hw_upd && (hw_idx == IDX_W'(i));

    txd_slot u_slot (
      .clk       (clk),
      .rst       (rst),
      .wr_acc    (sel_wr),
      .wr_thr    (host_wr_data[21:16]),
      .wr_own    (host_wr_data[13]),
      .wr_size   (host_wr_data[12:0]),
      .upd_own   (sel_hw && hw_own_set),
      .upd_stat  (sel_hw && hw_stat_load),
      .stat_in   (stat_in),
      .start_clr (start_clr[i]),
      .word      (words[i]),
      .own       (own_vec[i]),
      .armed     (armed_vec[i]),
      .size      (size_vec[i]),
      .thr       (thr_vec[i]),
      .stat_nz   (stat_nz[i]),
      .hbf       (hbf_vec[i])
    );

    txd_thresh #(.THR_W(THR_W), .LVL_W(LVL_W)) u_thr (
      .code  (thr_vec[i]),
      .bytes (thr_bytes[i])
    );
  end

  txd_sched #(
    .NDESC(NDESC), .LVL_W(LVL_W), .SIZE_W(SIZE_W), .LONG_LIM(LONG_LIM)
  ) u_sched (
    .clk           (clk),
    .rst           (rst),
    .armed         (armed_vec),
    .own           (own_vec),
    .size          (size_vec),
    .thr_bytes     (thr_bytes),
    .fifo_level    (fifo_level),
    .fifo_pkt_done (fifo_pkt_done),
    .start_clr     (start_clr),
    .tx_start      (tx_start),
    .tx_start_idx  (tx_start_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) host_rd_data <= '0;
    else     host_rd_data <= words[host_rd_addr];
  end
endmodule

// File: rtl/txdesc_bank_chk.sv
module txdesc_bank_chk #(
  parameter int NDESC = 4,
  parameter int IDX_W = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   host_wr_en,
  input logic [IDX_W-1:0]       host_wr_addr,
  input logic [3:0]             host_be,
  input logic                   link_100m,
  input logic                   hw_upd,
  input logic [IDX_W-1:0]       hw_idx,
  input logic                   hw_own_set,
  input logic                   hw_stat_load,
  input logic                   tx_start,
  input logic [IDX_W-1:0]       tx_start_idx,
  input logic [NDESC-1:0][31:0] words,
  input logic [NDESC-1:0]       own_vec,
  input logic [NDESC-1:0]       stat_nz,
  input logic [NDESC-1:0]       hbf_vec
);
  // R1
  reset_own_chk: assert property (@(posedge clk) rst |=> (own_vec == '1));

  // R5
  partial_write_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && host_be != 4'hF && !hw_upd) |=> $stable(words));

  // R4
  write_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && host_be == 4'hF && !(hw_upd && hw_stat_load && hw_idx == host_wr_addr))
    |=> !stat_nz[$past(host_wr_addr)]);

  // R7
  hbf_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_upd && hw_stat_load && link_100m) |=> !hbf_vec[$past(hw_idx)]);

  // R8
  own_set_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_upd && hw_own_set) |=> own_vec[$past(hw_idx)]);

  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_start && $past(tx_start)) |-> (tx_start_idx != $past(tx_start_idx)));
endmodule

bind txdesc_bank txdesc_bank_chk #(.NDESC(NDESC), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .host_wr_en   (host_wr_en),
  .host_wr_addr (host_wr_addr),
  .host_be      (host_be),
  .link_100m    (link_100m),
  .hw_upd       (hw_upd),
  .hw_idx       (hw_idx),
  .hw_own_set   (hw_own_set),
  .hw_stat_load (hw_stat_load),
  .tx_start     (tx_start),
  .tx_start_idx (tx_start_idx),
  .words        (words),
  .own_vec      (own_vec),
  .stat_nz      (stat_nz),
  .hbf_vec      (hbf_vec)
);

// File: tb/tb_txdesc_bank.sv
`timescale 1ns/1ps
module tb_txdesc_bank;
  localparam int NDESC = 4;
  localparam int LVL_W = 12;
  localparam int IDX_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr_en = 1'b0;
  logic [IDX_W-1:0] host_wr_addr = '0;
  logic [31:0] host_wr_data = '0;
  logic [3:0]  host_be = '0;
  logic [IDX_W-1:0] host_rd_addr = '0;
  logic [31:0] host_rd_data;
  logic link_100m = 1'b0;
  logic hw_upd = 1'b0;
  logic [IDX_W-1:0] hw_idx = '0;
  logic hw_own_set = 1'b0, hw_stat_load = 1'b0;
  logic hw_crs = 1'b0, hw_tabt = 1'b0, hw_owc = 1'b0, hw_hbf = 1'b0;
  logic [3:0] hw_ncc = '0;
  logic hw_tok = 1'b0, hw_tun = 1'b0;
  logic [LVL_W-1:0] fifo_level = '0;
  logic fifo_pkt_done = 1'b0;
  logic tx_start;
  logic [IDX_W-1:0] tx_start_idx;

  always #2 clk = ~clk;

  txdesc_bank #(.NDESC(NDESC), .LVL_W(LVL_W)) dut (.*);

  int n_chk = 0, n_bad = 0, n_start = 0;
  logic [IDX_W-1:0] last_idx = '0;
  logic [IDX_W-1:0] head_exp = '0;

  always @(negedge clk) if (tx_start) begin
    n_start  = n_start + 1;
    last_idx = tx_start_idx;
  end

  // {code[5:0], level[11:0], pkt_done, expect_start}
  localparam logic [19:0] VEC [12] = '{
    {6'd0,  12'd7,    1'b0, 1'b0},
    {6'd0,  12'd8,    1'b0, 1'b1},
    {6'd1,  12'd31,   1'b0, 1'b0},
    {6'd1,  12'd32,   1'b0, 1'b1},
    {6'd2,  12'd63,   1'b0, 1'b0},
    {6'd2,  12'd64,   1'b0, 1'b1},
    {6'd63, 12'd2015, 1'b0, 1'b0},
    {6'd63, 12'd2016, 1'b0, 1'b1},
    {6'd5,  12'd0,    1'b1, 1'b1},
    {6'd10, 12'd100,  1'b0, 1'b0},
    {6'd10, 12'd320,  1'b0, 1'b1},
    {6'd4,  12'd4095, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic host_wr(input logic [IDX_W-1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_addr = a; host_wr_data = d; host_be = be;
    @(negedge clk);
    host_wr_en = 1'b0; host_be = '0;
  endtask

  task automatic host_rd(input logic [IDX_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd_addr = a;
    @(negedge clk);
    d = host_rd_data;
  endtask

  task automatic hw_set(input logic [IDX_W-1:0] a, input logic own_s, input logic ld,
                        input logic [9:0] flags);
    hw_upd = 1'b1; hw_idx = a; hw_own_set = own_s; hw_stat_load = ld;
    {hw_crs, hw_tabt, hw_owc, hw_hbf, hw_ncc, hw_tok, hw_tun} = flags;
  endtask

  task automatic hw_clr();
    hw_upd = 1'b0; hw_own_set = 1'b0; hw_stat_load = 1'b0;
  endtask

  task automatic hw_pulse(input logic [IDX_W-1:0] a, input logic own_s, input logic ld,
                          input logic [9:0] flags);
    @(negedge clk);
    hw_set(a, own_s, ld, flags);
    @(negedge clk);
    hw_clr();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int s0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state of every word
    for (int i = 0; i < NDESC; i++) begin
      host_rd(IDX_W'(i), rd);
      chk("R1 reset word", rd, 32'h0000_2000);
    end

    // R2 R3 writable fields, reserved and read-only bits
    host_wr(2'd1, 32'hFFFF_FFFF, 4'hF);
    host_rd(2'd1, rd);
    chk("R2 R3 full write of ones", rd, 32'h003F_3FFF);

    // R5 partial byte enables ignored
    host_wr(2'd1, 32'h0000_0000, 4'b0111);
    host_rd(2'd1, rd);
    chk("R5 partial write ignored", rd, 32'h003F_3FFF);

    // R6 status load positions (10 Mbps link)
    hw_pulse(2'd2, 1'b0, 1'b1, {4'b1111, 4'd5, 2'b11});
    host_rd(2'd2, rd);
    chk("R6 status positions", rd, 32'hF500_E000);

    // R4 full write clears status
    host_wr(2'd2, 32'h0000_2040, 4'hF);
    host_rd(2'd2, rd);
    chk("R4 write clears status", rd, 32'h0000_2040);

    // R7 heartbeat masked at 100 Mbps
    link_100m = 1'b1;
    hw_pulse(2'd3, 1'b0, 1'b1, {4'b0001, 4'd0, 2'b00});
    link_100m = 1'b0;
    host_rd(2'd3, rd);
    chk("R7 heartbeat masked", rd, 32'h0000_2000);

    // R8 engine sets ownership
    host_wr(2'd3, 32'h0000_0000, 4'hF);
    host_rd(2'd3, rd);
    chk("R8 own cleared by host", rd, 32'h0000_0000);
    hw_pulse(2'd3, 1'b1, 1'b0, 10'd0);
    host_rd(2'd3, rd);
    chk("R8 own set by engine", rd, 32'h0000_2000);

    // R9 same-cycle host write and status load
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_addr = 2'd1; host_wr_data = 32'h0000_2010; host_be = 4'hF;
    hw_set(2'd1, 1'b0, 1'b1, {4'b0000, 4'd3, 2'b10});
    @(negedge clk);
    host_wr_en = 1'b0; host_be = '0; hw_clr();
    host_rd(2'd1, rd);
    chk("R9 engine wins status", rd, 32'h0300_A010);

    // R13 read latency of one clock
    host_rd(2'd2, rd);
    @(negedge clk);
    host_rd_addr = 2'd1;
    #1 chk("R13 old data before edge", host_rd_data, 32'h0000_2040);
    @(negedge clk);
    chk("R13 new data after edge", host_rd_data, 32'h0300_A010);

    // R10 R11 threshold vectors
    for (int v = 0; v < 12; v++) begin
      logic [5:0]  code;
      logic [11:0] lvl;
      logic        pd, ex;
      {code, lvl, pd, ex} = VEC[v];
      @(negedge clk);
      fifo_level = lvl; fifo_pkt_done = pd;
      s0 = n_start;
      host_wr(head_exp, {10'd0, code, 3'b000, 13'd100}, 4'hF);
      repeat (3) @(negedge clk);
      chk("R10 start vs threshold", 32'(n_start - s0), ex ? 32'd1 : 32'd0);
      if (!ex) begin
        fifo_pkt_done = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 R11 complete packet single start", 32'(n_start - s0), 32'd1);
      end
      chk("R10 start index", 32'(last_idx), 32'(head_exp));
      head_exp = head_exp + 1'b1;
      fifo_pkt_done = 1'b0; fifo_level = '0;
    end

    // R12 long packet holds the ring
    fifo_pkt_done = 1'b1;
    s0 = n_start;
    host_wr(head_exp, {19'd0, 13'd1800}, 4'hF);
    repeat (2) @(negedge clk);
    host_wr(head_exp + 1'b1, {19'd0, 13'd100}, 4'hF);
    repeat (4) @(negedge clk);
    chk("R12 held after long packet", 32'(n_start - s0), 32'd1);
    hw_pulse(head_exp, 1'b1, 1'b0, 10'd0);
    repeat (4) @(negedge clk);
    chk("R12 released by ownership", 32'(n_start - s0), 32'd2);
    chk("R12 next index", 32'(last_idx), 32'(head_exp + 1'b1));
    head_exp = head_exp + 2'd2;

    // R12 exactly 1792 does not hold
    s0 = n_start;
    host_wr(head_exp, {19'd0, 13'd1792}, 4'hF);
    host_wr(head_exp + 1'b1, {19'd0, 13'd64}, 4'hF);
    repeat (4) @(negedge clk);
    chk("R12 limit count does not hold", 32'(n_start - s0), 32'd2);
    head_exp = head_exp + 2'd2;

    // R11 owned descriptor never starts
    s0 = n_start;
    host_wr(head_exp, 32'h0000_2100, 4'hF);
    repeat (4) @(negedge clk);
    chk("R11 owned descriptor no start", 32'(n_start - s0), 32'd0);
    fifo_pkt_done = 1'b0;

    finish_run();
  end
endmodule